// File: doc/BRIEF.md
# NOR Flash Command-Sequence Decoder

This block sits on the device side of a 16-bit NOR flash bus. It watches the asynchronous chip-enable and write-enable strobes, treats each properly formed write as a command word, and follows the unlock protocol that selects what a read returns. A read can come from one of three places: the storage array, the identification space or the query space. The block does not drive array data itself. It reports which source is active and supplies the identification or query word for the read address it is given.

The strobes are sampled on a fast local clock. A write counts only when both strobes have been low together for a minimum number of samples. The write is taken when write-enable rises while chip-enable is still low, and it uses the address and data present at that sample. The sector-protect flags and the factory-lock flag arrive as inputs from logic outside the block.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, read_mode is 0 (array) and info_data is 0.
- R2: Three accepted writes in a row switch read_mode to 1 (identification): 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555. Commands are decoded from data bits [7:0] and address bits [10:0]. This works from any mode.
- R3: Any accepted write that breaks the three-write pattern, whether through the wrong address or the wrong data, returns the pattern tracker to its start without changing read_mode.
- R4: An accepted write of 0x98 to address 0x055 (bits [10:0]) switches read_mode to 2 (query) from any mode and returns the tracker to its start.
- R5: An accepted write of 0xF0 to any address switches read_mode to 0 and returns the tracker to its start. This command takes precedence over all others.
- R6: In identification mode, read offsets (rd_addr[7:0]) 0x00, 0x01, 0x0E and 0x0F return 0x0001, 0x227E, 0x2223 and 0x2201.
- R7: In identification mode, offset 0x02 returns 0x0001 if the sector selected by rd_addr[15:13] has its bit set in sect_prot, and 0x0000 if it does not.
- R8: In identification mode, offset 0x03 returns 0x0098 when fact_locked is 1 and 0x0018 when it is 0.
- R9: In query mode, offsets 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059.
- R10: In array mode, info_data is 0. In the other two modes, any offset not listed above also returns 0.
- R11: A write counts only if ce_n and we_n were both low for at least MIN_LOW consecutive clock samples before we_n rises. A shorter low pulse has no effect.
- R12: A write is captured at the first sample where we_n is high, provided ce_n is low at that same sample. The capture uses the addr and wdata of that sample. If ce_n is high there, no write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address on the bus during a write |
| wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the current read |
| sect_prot | input | 2**SECT_W | Protect flag for each sector |
| fact_locked | input | 1 | Factory-lock state of the secure region |
| read_mode | output | 2 | Active read source: 0 array, 1 identification, 2 query |
| info_data | output | DATA_W | Identification or query word for rd_addr |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=16, SECT_W=3 and MIN_LOW=3. With eight sectors, the protect flag of every sector can be addressed through rd_addr[15:13]. A filter length of three lets the bench place pulses of one or two samples, which must be rejected, right next to pulses of three to five samples, which must be accepted. Random writes aimed mostly at the three command addresses and the five command codes, with random upper bits, exercise broken sequences, restarts and the precedence of the exit command.

// File: rtl/nfcd_pkg.sv
package nfcd_pkg;

    localparam int CMD_AW = 11;
    localparam int CMD_DW = 8;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_IDENT = 2'd1,
        RM_QUERY = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        UL_IDLE   = 2'd0,
        UL_FIRST  = 2'd1,
        UL_SECOND = 2'd2
    } unlock_e;

    typedef struct packed {
        logic [CMD_AW-1:0] loc;
        logic [CMD_DW-1:0] code;
    } cmd_word_t;

    localparam logic [CMD_AW-1:0] LOC_KEY_A = 11'h555;
    localparam logic [CMD_AW-1:0] LOC_KEY_B = 11'h2AA;
    localparam logic [CMD_AW-1:0] LOC_QUERY = 11'h055;

    localparam logic [CMD_DW-1:0] CODE_KEY_A = 8'hAA;
    localparam logic [CMD_DW-1:0] CODE_KEY_B = 8'h55;
    localparam logic [CMD_DW-1:0] CODE_IDENT = 8'h90;
    localparam logic [CMD_DW-1:0] CODE_QUERY = 8'h98;
    localparam logic [CMD_DW-1:0] CODE_EXIT  = 8'hF0;

    localparam logic [7:0] SECURE_LOCKED = 8'h98;
    localparam logic [7:0] SECURE_OPEN   = 8'h18;

    function automatic logic cmd_is(cmd_word_t c, logic [CMD_AW-1:0] l, logic [CMD_DW-1:0] k);
        return (c.loc == l) && (c.code == k);
    endfunction

    function automatic logic [7:0] query_char(logic [7:0] ofs);
        case (ofs)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nfcd_strobe_filter.sv
module nfcd_strobe_filter #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_LOW);

    logic             both_low;
    logic             rise_ok;
    logic [CNT_W-1:0] low_cnt;

    assign both_low = !ce_n && !we_n;
    assign rise_ok  = (low_cnt == CNT_FULL) && we_n && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            if (!both_low)
                low_cnt <= '0;
            else if (low_cnt != CNT_FULL)
                low_cnt <= low_cnt + 1'b1;
            wr_valid <= rise_ok;
            if (rise_ok) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
        end
    end

    AST_WR_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(we_n && !ce_n)); // R12
    AST_WR_SPACED: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R11
    AST_WR_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(!we_n, 2)); // R11

endmodule

// File: rtl/nfcd_cmd_fsm.sv
module nfcd_cmd_fsm
    import nfcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rd_mode_e          mode
);
    cmd_word_t cw;
    unlock_e   ul_q, ul_d;
    rd_mode_e  mode_d;

    assign cw.loc  = wr_addr[CMD_AW-1:0];
    assign cw.code = wr_data[CMD_DW-1:0];

    always_comb begin
        ul_d   = ul_q;
        mode_d = mode;
        if (wr_valid) begin
            if (cw.code == CODE_EXIT) begin
                mode_d = RM_ARRAY;
                ul_d   = UL_IDLE;
            end else if (cmd_is(cw, LOC_QUERY, CODE_QUERY)) begin
                mode_d = RM_QUERY;
                ul_d   = UL_IDLE;
            end else begin
                case (ul_q)
                    UL_IDLE:   ul_d = cmd_is(cw, LOC_KEY_A, CODE_KEY_A) ? UL_FIRST : UL_IDLE;
                    UL_FIRST:  ul_d = cmd_is(cw, LOC_KEY_B, CODE_KEY_B) ? UL_SECOND : UL_IDLE;
                    UL_SECOND: begin
                        if (cmd_is(cw, LOC_KEY_A, CODE_IDENT))
                            mode_d = RM_IDENT;
                        ul_d = UL_IDLE;
                    end
                    default:   ul_d = UL_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ul_q <= UL_IDLE;
            mode <= RM_ARRAY;
        end else begin
            ul_q <= ul_d;
            mode <= mode_d;
        end
    end

    AST_EXIT_TO_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[7:0] == 8'hF0) |=> (mode == RM_ARRAY)); // R5
    AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[7:0] == 8'h98 && wr_addr[10:0] == 11'h055) |=> (mode == RM_QUERY)); // R4
    AST_IDENT_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        (mode == RM_IDENT && $past(mode) != RM_IDENT)
            |-> $past(wr_valid && wr_data[7:0] == 8'h90 && wr_addr[10:0] == 11'h555)); // R2
    AST_MISS_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[7:0] != 8'hF0 && wr_data[7:0] != 8'h98 && wr_data[7:0] != 8'h90)
            |=> $stable(mode)); // R3
    AST_IDLE_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(mode)); // R12

endmodule

// File: rtl/nfcd_info_mux.sv
module nfcd_info_mux
    import nfcd_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 16,
    parameter int              SECT_W   = 3,
    parameter logic [15:0]     MFR_CODE = 16'h0001,
    parameter logic [15:0]     DEV_ID1  = 16'h227E,
    parameter logic [15:0]     DEV_ID2  = 16'h2223,
    parameter logic [15:0]     DEV_ID3  = 16'h2201
) (
    input  logic                   clk,
    input  logic                   rst,
    input  rd_mode_e               mode,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    input  logic                   fact_locked,
    output logic [DATA_W-1:0]      info_data
);
    logic [7:0]        ofs;
    logic [SECT_W-1:0] sect;

    assign ofs  = rd_addr[7:0];
    assign sect = rd_addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        info_data = '0;
        case (mode)
            RM_IDENT: begin
                case (ofs)
                    8'h00:   info_data = DATA_W'(MFR_CODE);
                    8'h01:   info_data = DATA_W'(DEV_ID1);
                    8'h0E:   info_data = DATA_W'(DEV_ID2);
                    8'h0F:   info_data = DATA_W'(DEV_ID3);
                    8'h02:   info_data = DATA_W'(sect_prot[sect]);
                    8'h03:   info_data = DATA_W'(fact_locked ? SECURE_LOCKED : SECURE_OPEN);
                    default: info_data = '0;
                endcase
            end
            RM_QUERY: info_data = DATA_W'(query_char(ofs));
            default:  info_data = '0;
        endcase
    end

    AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == RM_ARRAY) |-> (info_data == '0)); // R10
    AST_PROT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (mode == RM_IDENT && rd_addr[7:0] == 8'h02) |-> (info_data[DATA_W-1:1] == '0)); // R7

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nfcd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int SECT_W  = 3,
    parameter int MIN_LOW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    input  logic                   fact_locked,
    output logic [1:0]             read_mode,
    output logic [DATA_W-1:0]      info_data
);
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    rd_mode_e          mode;

    nfcd_strobe_filter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MIN_LOW(MIN_LOW)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    nfcd_cmd_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode    (mode)
    );

    nfcd_info_mux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SECT_W(SECT_W)
    ) u_mux (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .rd_addr    (rd_addr),
        .sect_prot  (sect_prot),
        .fact_locked(fact_locked),
        .info_data  (info_data)
    );

    assign read_mode = mode;

    AST_RESET_ARRAY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (read_mode == 2'd0)); // R1
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        read_mode != 2'd3); // R2

endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SW = 3;
    localparam int ML = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    sect_prot = '0;
    logic          fact_locked = 1'b0;
    logic [1:0]    read_mode;
    logic [DW-1:0] info_data;

    int checks = 0;
    int errors = 0;
    int m_mode = 0;
    int m_ul = 0;

    always #4 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .MIN_LOW(ML)) i_nor_cmd_decoder (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .sect_prot(sect_prot), .fact_locked(fact_locked),
        .read_mode(read_mode), .info_data(info_data)
    );

    function automatic void model_write(logic [15:0] a, logic [15:0] d);
        logic [10:0] l = a[10:0];
        logic [7:0]  k = d[7:0];
        if (k == 8'hF0) begin m_mode = 0; m_ul = 0; end
        else if (l == 11'h055 && k == 8'h98) begin m_mode = 2; m_ul = 0; end
        else case (m_ul)
            0: m_ul = (l == 11'h555 && k == 8'hAA) ? 1 : 0;
            1: m_ul = (l == 11'h2AA && k == 8'h55) ? 2 : 0;
            default: begin
                if (l == 11'h555 && k == 8'h90) m_mode = 1;
                m_ul = 0;
            end
        endcase
    endfunction

    function automatic logic [15:0] exp_info(int md, logic [15:0] ra, logic [7:0] pr, logic lk);
        logic [7:0] o = ra[7:0];
        if (md == 1) begin
            case (o)
                8'h00: return 16'h0001;
                8'h01: return 16'h227E;
                8'h0E: return 16'h2223;
                8'h0F: return 16'h2201;
                8'h02: return {15'd0, pr[ra[15:13]]};
                8'h03: return lk ? 16'h0098 : 16'h0018;
                default: return 16'h0000;
            endcase
        end else if (md == 2) begin
            case (o)
                8'h10: return 16'h0051;
                8'h11: return 16'h0052;
                8'h12: return 16'h0059;
                default: return 16'h0000;
            endcase
        end
        return 16'h0000;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives wrong addr/data during the low phase and the real values at the we_n rise.
    task automatic bus_write(logic [15:0] a, logic [15:0] d, int low, bit ce_hi = 0);
        @(negedge clk);
        ce_n = 0; we_n = 0; addr = ~a; wdata = ~d;
        repeat (low) @(negedge clk);
        addr = a; wdata = d; we_n = 1; ce_n = ce_hi;
        @(negedge clk);
        ce_n = 1;
        repeat (3) @(negedge clk);
        if (low >= ML && !ce_hi) model_write(a, d);
    endtask

    task automatic rd(string tag, logic [15:0] ra, logic [15:0] exp);
        @(negedge clk);
        rd_addr = ra;
        #1;
        chk(tag, {16'd0, info_data}, {16'd0, exp});
    endtask

    task automatic mode_is(string tag, int exp);
        #1;
        chk(tag, {30'd0, read_mode}, exp);
    endtask

    task automatic ident_seq();
        bus_write(16'h0555, 16'h00AA, 3);
        bus_write(16'h02AA, 16'h0055, 3);
        bus_write(16'h0555, 16'h0090, 3);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pa [4] = '{16'h0555, 16'h02AA, 16'h0055, 16'h0000};
        logic [7:0]  pd [6] = '{8'hAA, 8'h55, 8'h90, 8'h98, 8'hF0, 8'h00};
        logic [7:0]  po [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12, 8'h00};
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        mode_is("R1 reset mode", 0);
        rd("R1 reset info", 16'h0010, 16'h0000);

        // R2 identification entry, R6 identity words
        ident_seq();
        mode_is("R2 ident entry", 1);
        rd("R6 mfr", 16'h0000, 16'h0001);
        rd("R6 dev1", 16'h0001, 16'h227E);
        rd("R6 dev2", 16'h000E, 16'h2223);
        rd("R6 dev3", 16'h000F, 16'h2201);
        sect_prot = 8'b0010_0100;
        rd("R7 sector2 protected", 16'h4002, 16'h0001);
        rd("R7 sector0 open", 16'h0002, 16'h0000);
        rd("R7 sector5 protected", 16'hA002, 16'h0001);
        fact_locked = 1;
        rd("R8 locked", 16'h0003, 16'h0098);
        fact_locked = 0;
        rd("R8 open", 16'h0003, 16'h0018);
        rd("R10 ident unlisted", 16'h0010, 16'h0000);

        // R5 exit from any address
        bus_write(16'h1234, 16'h00F0, 3);
        mode_is("R5 exit", 0);
        rd("R10 array quiet", 16'h0000, 16'h0000);

        // R4 query entry, upper address bits ignored
        bus_write(16'h0855, 16'h0098, 3);
        mode_is("R4 query entry", 2);
        rd("R9 Q", 16'h0010, 16'h0051);
        rd("R9 R", 16'h0011, 16'h0052);
        rd("R9 Y", 16'h0012, 16'h0059);
        rd("R10 query unlisted", 16'h0013, 16'h0000);

        // R3 broken pattern keeps mode, tracker back at start
        bus_write(16'h0555, 16'h00AA, 3);
        bus_write(16'h02AA, 16'h0055, 3);
        bus_write(16'h0555, 16'h0091, 3);
        mode_is("R3 wrong data keeps mode", 2);
        bus_write(16'h0555, 16'h0090, 3);
        mode_is("R3 tracker reset", 2);
        bus_write(16'h0555, 16'h00AA, 3);
        bus_write(16'h02AB, 16'h0055, 3);
        bus_write(16'h0555, 16'h0090, 3);
        mode_is("R3 wrong address", 2);

        // R12 no write if ce_n high at the rise
        bus_write(16'h0000, 16'h00F0, 3, 1);
        mode_is("R12 ce high at rise", 2);

        // R2 from query mode
        ident_seq();
        mode_is("R2 ident from query", 1);

        // R5 exit mid-sequence clears tracker
        bus_write(16'h0555, 16'h00AA, 3);
        bus_write(16'h0000, 16'h00F0, 3);
        bus_write(16'h02AA, 16'h0055, 3);
        bus_write(16'h0555, 16'h0090, 3);
        mode_is("R5 exit mid sequence", 0);

        // R11 pulse length filter
        bus_write(16'h0055, 16'h0098, 2);
        mode_is("R11 short pulse dropped", 0);
        bus_write(16'h0055, 16'h0098, 1);
        mode_is("R11 one-sample pulse dropped", 0);
        bus_write(16'h0055, 16'h0098, 3);
        mode_is("R11 minimum pulse accepted", 2);
        bus_write(16'h0000, 16'h00F0, 5);

        // random traffic checked against the model
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, d, ra;
            int low;
            a = pa[$urandom_range(0, 3)];
            if (a == 16'h0000) a = 16'($urandom);
            else a = {5'($urandom), a[10:0]};
            d = {8'($urandom), pd[$urandom_range(0, 5)]};
            if (d[7:0] == 8'h00) d[7:0] = 8'($urandom);
            if (d[7:0] == 8'hF0 && $urandom_range(0, 2) != 0) d[7:0] = 8'hAA;
            low = $urandom_range(1, 5);
            sect_prot = 8'($urandom);
            fact_locked = 1'($urandom);
            bus_write(a, d, low);
            mode_is("R2 R3 R4 R5 R11 random mode", m_mode);
            ra = 16'($urandom);
            ra[7:0] = po[$urandom_range(0, 9)];
            rd("R6 R7 R8 R9 R10 random read", ra, exp_info(m_mode, ra, sect_prot, fact_locked));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule